// File: doc/BRIEF.md
# Windowed PRBS Error Counter for a TDM Stream

This block receives the bytes of one channel-aligned time-division-multiplexed stream, one byte per strobe, each tagged with its channel number. A programmable window of adjacent channels within every frame is taken to carry a test sequence from a 15-stage pseudo-random generator. Every bit of the window bytes is compared against a locally generated copy of that sequence, and the mismatches are added to a saturating 16-bit total.

Software sets a start channel and a window length, sets the enable bit and reads the total. The local generator is loaded from the first received window bytes after arming. It then runs only while window bytes arrive, so the sequence carries on from one frame's window to the next. Bytes outside the window are never compared. A clear bit in the same control field resets the total.

Top module: `ber_window_checker`

## Requirements
- R1: After reset, `errCount` is 0.
- R2: A byte is compared only when `slotValid` is high and `cfgStart <= slotIndex < cfgStart + cfgLength`. Every other byte leaves `errCount` and the reference sequence unchanged.
- R3: `cfgLength` is a 9-bit count from 1 to 256 channels. A window that runs past the last channel of the frame covers only the channels that exist.
- R4: After the checker is enabled, no window byte is used until a `frameStart` pulse has been seen. The byte strobed in the same cycle as that pulse counts as the first byte of the new frame.
- R5: The first two window bytes after `frameStart` load the reference register with the most recent 15 received bits. They add no errors. Comparison begins with the third window byte.
- R6: The reference follows b[n] = b[n-15] XOR b[n-14]. It advances one bit per compared bit, with bit 7 of each byte first. It does not advance outside the window, so the sequence continues across frames.
- R7: Each compared byte adds the number of bits in which it differs from the reference byte (0 to 8). The total becomes visible one clock edge after the byte is strobed.
- R8: The total stops at 0xFFFF and never wraps.
- R9: `ctrlBits[1]` forces the total to 0 at the next edge. It wins over an update in the same cycle.
- R10: While `ctrlBits[0]` is low, nothing is compared and the total holds. Setting it again restarts the frame wait of R4 and the loading of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotValid | input | 1 | A channel byte is present this cycle |
| slotIndex | input | 8 | Channel number of the byte |
| slotByte | input | 8 | Received byte |
| frameStart | input | 1 | Pulse marking the beginning of a frame |
| ctrlBits | input | 2 | Bit 0 enable, bit 1 clear total |
| cfgStart | input | 8 | First channel of the window |
| cfgLength | input | 9 | Number of window channels |
| errCount | output | 16 | Saturating bit-error total |

## Verification
Several properties are checked on every cycle. Updates happen only for in-window valid bytes, and no step exceeds eight. A total of 0xFFFF holds, and a clear yields zero. The control only reaches the comparing state through the loading sequence, and only leaves the frame wait on a frame pulse. Other behaviour can only be shown by bench scenarios with a known stream and injected bit flips. These cover the exact error totals, the correct generator polynomial and bit order, continuation of the sequence across frames, and windows clipped at the end of the frame.

// File: rtl/ber_chk_pkg.sv
package ber_chk_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_SEED0 = 3'd2,
    ST_SEED1 = 3'd3,
    ST_RUN   = 3'd4
  } chkState_t;

  typedef struct packed {
    logic seedByte;
    logic compareByte;
    logic clearCount;
  } chkStrobe_t;

endpackage

// File: rtl/ber_chk_ctrl.sv
module ber_chk_ctrl
  import ber_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlEnable,
  input  logic       ctrlClear,
  input  logic       slotValid,
  input  logic       frameStart,
  input  logic       inWindow,
  output chkStrobe_t strb
);

  chkState_t state, stateNext, effState;
  logic hit;

  assign hit = slotValid && inWindow;

  always_comb begin
    effState = state;
    if (state == ST_WAIT && frameStart) effState = ST_SEED0;
  end

  always_comb begin
    strb.clearCount  = ctrlClear;
    strb.seedByte    = ctrlEnable && hit && (effState == ST_SEED0 || effState == ST_SEED1);
    strb.compareByte = ctrlEnable && hit && (effState == ST_RUN);
  end

  always_comb begin
    stateNext = effState;
    if (!ctrlEnable) begin
      stateNext = ST_OFF;
    end else begin
      case (effState)
        ST_OFF:   stateNext = ST_WAIT;
        ST_WAIT:  stateNext = ST_WAIT;
        ST_SEED0: stateNext = hit ? ST_SEED1 : ST_SEED0;
        ST_SEED1: stateNext = hit ? ST_RUN : ST_SEED1;
        ST_RUN:   stateNext = ST_RUN;
        default:  stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  // R10: dropping enable always returns to the idle state
  assert_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEnable |=> state == ST_OFF);

  // R5: comparing is only entered after the second loading byte
  assert_run_after_seed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) != ST_RUN) |-> $past(state) == ST_SEED1);

  // R4: the frame wait ends only on a frame pulse (or on disable)
  assert_wait_needs_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_WAIT && state != ST_WAIT && state != ST_OFF) |-> $past(frameStart));

endmodule

// File: rtl/ber_chk_dp.sv
module ber_chk_dp
  import ber_chk_pkg::*;
#(
  parameter int CHAN_W  = 8,
  parameter int LEN_W   = 9,
  parameter int BYTE_W  = 8,
  parameter int PRBS_W  = 15,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotValid,
  input  logic [CHAN_W-1:0] slotIndex,
  input  logic [BYTE_W-1:0] slotByte,
  input  logic [CHAN_W-1:0] cfgStart,
  input  logic [LEN_W-1:0]  cfgLength,
  input  chkStrobe_t        strb,
  output logic              inWindow,
  output logic [CNT_W-1:0]  errCount
);

  localparam int SUM_W   = LEN_W + 1;
  localparam int TAP_HI  = PRBS_W - 1;
  localparam int TAP_LO  = PRBS_W - 2;
  localparam int KEEP_W  = PRBS_W - BYTE_W;
  localparam int PC_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PRBS_W-1:0] prbsState, prbsAdvanced;
  logic [BYTE_W-1:0] expByte, diffByte;
  logic [PC_W-1:0]   diffCount;
  logic [CNT_W:0]    sumWide;
  logic [SUM_W-1:0]  windowEnd;

  // Window decode
  always_comb begin
    windowEnd = SUM_W'(cfgStart) + SUM_W'(cfgLength);
    inWindow  = (slotIndex >= cfgStart) && (SUM_W'(slotIndex) < windowEnd);
  end

  // Reference byte: one recurrence step per bit, first bit in the top position
  always_comb begin
    logic [PRBS_W-1:0] s;
    logic              b;
    s = prbsState;
    expByte = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      b = s[TAP_HI] ^ s[TAP_LO];
      expByte[i] = b;
      s = {s[PRBS_W-2:0], b};
    end
    prbsAdvanced = s;
  end

  assign diffByte = slotByte ^ expByte;

  always_comb begin
    diffCount = '0;
    for (int i = 0; i < BYTE_W; i++) diffCount = diffCount + PC_W'(diffByte[i]);
  end

  assign sumWide = {1'b0, errCount} + (CNT_W+1)'(diffCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prbsState <= '0;
    end else if (strb.seedByte) begin
      prbsState <= {prbsState[KEEP_W-1:0], slotByte};
    end else if (strb.compareByte) begin
      prbsState <= prbsAdvanced;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCount <= '0;
    end else if (strb.clearCount) begin
      errCount <= '0;
    end else if (strb.compareByte) begin
      errCount <= sumWide[CNT_W] ? CNT_MAX : sumWide[CNT_W-1:0];
    end
  end

  // R2: strobes from the control only arrive for valid in-window bytes
  assert_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.compareByte || strb.seedByte) |-> (slotValid && inWindow));

  // R2: with no compare and no clear the total is stable
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.compareByte && !strb.clearCount) |=> $stable(errCount));

  // R7: a step never decreases and adds at most one byte's worth
  assert_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearCount |=> (errCount >= $past(errCount)) &&
                         ((errCount - $past(errCount)) <= CNT_W'(BYTE_W)));

  // R8: a saturated total stays saturated
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == CNT_MAX && !strb.clearCount) |=> errCount == CNT_MAX);

  // R9: clear always lands as zero
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCount |=> errCount == '0);

endmodule

// File: rtl/ber_window_checker.sv
module ber_window_checker
  import ber_chk_pkg::*;
#(
  parameter int CHAN_W = 8,
  parameter int LEN_W  = 9,
  parameter int BYTE_W = 8,
  parameter int PRBS_W = 15,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotValid,
  input  logic [CHAN_W-1:0] slotIndex,
  input  logic [BYTE_W-1:0] slotByte,
  input  logic              frameStart,
  input  logic [1:0]        ctrlBits,
  input  logic [CHAN_W-1:0] cfgStart,
  input  logic [LEN_W-1:0]  cfgLength,
  output logic [CNT_W-1:0]  errCount
);

  chkStrobe_t strb;
  logic       inWindow;

  ber_chk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlEnable (ctrlBits[0]),
    .ctrlClear  (ctrlBits[1]),
    .slotValid  (slotValid),
    .frameStart (frameStart),
    .inWindow   (inWindow),
    .strb       (strb)
  );

  ber_chk_dp #(
    .CHAN_W (CHAN_W),
    .LEN_W  (LEN_W),
    .BYTE_W (BYTE_W),
    .PRBS_W (PRBS_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .slotValid (slotValid),
    .slotIndex (slotIndex),
    .slotByte  (slotByte),
    .cfgStart  (cfgStart),
    .cfgLength (cfgLength),
    .strb      (strb),
    .inWindow  (inWindow),
    .errCount  (errCount)
  );

endmodule

// File: tb/test_ber_window_checker.sv
module test_ber_window_checker;

  localparam int FRAME  = 64;
  localparam int NVEC   = 6;

  logic        clk = 1'b0;
  logic        rstN;
  logic        slotValid;
  logic [7:0]  slotIndex;
  logic [7:0]  slotByte;
  logic        frameStart;
  logic [1:0]  ctrlBits;
  logic [7:0]  cfgStart;
  logic [8:0]  cfgLength;
  logic [15:0] errCount;

  int checks = 0;
  int errors = 0;
  int expCount = 0;
  int winNum = 0;
  logic [14:0] hist = 15'h2B5D;

  // start[24:17], length[16:8], flip mask[7:0]
  localparam logic [24:0] VEC [NVEC] = '{
    {8'd0,  9'd1,   8'h01},
    {8'd0,  9'd64,  8'h00},
    {8'd10, 9'd5,   8'h81},
    {8'd60, 9'd8,   8'h0F},
    {8'd20, 9'd256, 8'h10},
    {8'd33, 9'd3,   8'hFF}
  };

  ber_window_checker i_ber_window_checker (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotIndex(slotIndex),
    .slotByte(slotByte), .frameStart(frameStart), .ctrlBits(ctrlBits),
    .cfgStart(cfgStart), .cfgLength(cfgLength), .errCount(errCount)
  );

  always #4 clk = ~clk;

  function automatic int ones8(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic bit inWin(input int idx);
    return (idx >= int'(cfgStart)) && (idx < int'(cfgStart) + int'(cfgLength));
  endfunction

  // Next byte of the test sequence, first generated bit in bit 7
  function automatic logic [7:0] nextSeqByte();
    logic [7:0] r;
    logic nb;
    for (int i = 7; i >= 0; i--) begin
      nb = hist[14] ^ hist[13];
      r[i] = nb;
      hist = {hist[13:0], nb};
    end
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one window byte (caller has already waited for the falling edge)
  task automatic putWin(input int idx, input logic [7:0] mask, input logic fs);
    logic [7:0] b;
    b = nextSeqByte();
    slotValid = 1'b1; slotIndex = 8'(idx); frameStart = fs;
    if (winNum >= 2) begin
      slotByte = b ^ mask;
      expCount += ones8(mask);
      if (expCount > 65535) expCount = 65535;
    end else begin
      slotByte = b;
    end
    winNum++;
  endtask

  task automatic putOther(input int idx, input logic fs);
    slotValid = 1'b1; slotIndex = 8'(idx); frameStart = fs;
    slotByte = 8'h5A ^ 8'(idx * 7);
  endtask

  task automatic runFrames(input int n, input logic [7:0] mask);
    for (int f = 0; f < n; f++) begin
      for (int idx = 0; idx < FRAME; idx++) begin
        @(negedge clk);
        if (inWin(idx)) putWin(idx, mask, idx == 0);
        else            putOther(idx, idx == 0);
      end
    end
    @(negedge clk);
    slotValid = 1'b0; frameStart = 1'b0;
  endtask

  // Disable with clear, then enable; expectation restarts from zero
  task automatic rearm();
    @(negedge clk); ctrlBits = 2'b10; slotValid = 1'b0; frameStart = 1'b0;
    @(negedge clk); ctrlBits = 2'b01;
    expCount = 0; winNum = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; slotValid = 1'b0; slotIndex = '0; slotByte = '0;
    frameStart = 1'b0; ctrlBits = 2'b00; cfgStart = '0; cfgLength = 9'd1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset total", int'(errCount), 0);

    // Vector table: R2 R3 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      cfgStart  = VEC[v][24:17];
      cfgLength = VEC[v][16:8];
      rearm();
      runFrames(4, VEC[v][7:0]);
      check($sformatf("R2 R3 R5 R6 R7 vector %0d", v), int'(errCount), expCount);
    end

    // R4: window bytes without a frame pulse are not used
    cfgStart = 8'd0; cfgLength = 9'd64;
    rearm();
    for (int idx = 0; idx < FRAME; idx++) begin
      @(negedge clk); putOther(idx, 1'b0);
    end
    @(negedge clk); slotValid = 1'b0;
    check("R4 no frame pulse", int'(errCount), 0);

    // R8: saturation and no wrap
    rearm();
    runFrames(131, 8'hFF);
    check("R8 saturated", int'(errCount), 65535);
    runFrames(1, 8'h01);
    check("R8 still saturated", int'(errCount), 65535);

    // R9: clear wins over a same-cycle error update
    @(negedge clk); ctrlBits = 2'b11; putWin(0, 8'hFF, 1'b1);
    @(negedge clk); ctrlBits = 2'b01; putWin(1, 8'hFF, 1'b0);
    check("R9 clear priority", int'(errCount), 0);
    @(negedge clk); putWin(2, 8'h00, 1'b0);
    check("R7 eight flips after clear", int'(errCount), 8);
    @(negedge clk); slotValid = 1'b0;
    check("R7 clean byte adds nothing", int'(errCount), 8);

    // R10: disabled, garbage in window does nothing
    @(negedge clk); ctrlBits = 2'b00;
    for (int idx = 0; idx < FRAME; idx++) begin
      @(negedge clk); putOther(idx, idx == 0);
    end
    @(negedge clk); slotValid = 1'b0; frameStart = 1'b0;
    check("R10 disabled holds", int'(errCount), 8);

    // R10: re-enable reloads the reference, total kept
    @(negedge clk); ctrlBits = 2'b01;
    winNum = 0; expCount = 8;
    runFrames(1, 8'h01);
    check("R10 reload after enable", int'(errCount), 8 + 62);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule